// File: doc/BRIEF.md
# GPIO Interrupt Source Selector

This block turns pins of a wide GPIO input vector into interrupt requests. It has a fixed set of channels. Each channel has a select field that picks one pin by index and carries an enable bit. Each channel also has a two-bit sense code that chooses rising edge, falling edge, high level or low level. Every pin is passed through a two-flop synchroniser. The chosen pin then feeds a per-channel status flag, and that flag is driven out as an active-high level request to the parent interrupt controller.

Software programs the block through a simple 32-bit write/read register port:
- Select registers hold four byte-wide channel fields each.
- Sense registers hold sixteen two-bit codes each.
- A status register is read-only.
- A write-one-to-clear register releases latched edge flags.

Level-mode flags follow the pin and cannot be cleared by software. An edge that arrives in the same cycle as a clear is kept.

Changing a select or enable field can make the edge detector see a false transition. The intended software sequence is: change the field, wait at least one idle cycle, then write the clear register to remove any false flag.

Top module: `gpio_irq_selector`

## Requirements
- R1: After reset every status flag and every `irq_req` bit is 0, and all select and sense registers read 0.
- R2: Select register k is at 0x30+4k. Channel n uses byte n%4 of register n/4: bits [6:0] are the pin index and bit 7 is the enable. Sense register k is at 0x28+4k, and channel n uses bits [2(n%16)+1 : 2(n%16)] of register n/16. All of these read back what was written. The status register at 0x20 ignores writes, and the clear register at 0x24 reads 0.
- R3: Sense code 0 (rising edge) sets the flag 3 clocks after the pin rises, measured from the first clock edge that samples the new pin value. The flag then stays set after the pin falls, until it is cleared.
- R4: Sense code 1 (falling edge) sets the flag 3 clocks after the selected pin falls.
- R5: Sense code 2 makes the flag equal to the selected pin, and code 3 makes it equal to the inverse of the pin. Both have the same 3-clock latency, and a sense change takes effect one clock after the write.
- R6: Writing 1 to bit n of 0x24 clears flag n only in edge modes (codes 0 and 1). In level modes the write has no effect.
- R7: If an edge is detected in the same cycle a clear write for that channel is taken, the flag remains set.
- R8: While a channel's enable bit is 0, its flag and `irq_req` bit stay 0, and no edge or level is recorded.
- R9: Pin index values above 0x55 select a constant low input. 0x55 itself is a valid pin.
- R10: Enabling a rising-edge channel whose pin is already high sets a spurious flag one clock later. A clear written after one idle cycle removes it, and it does not return.
- R11: `irq_req[n]` is an active-high level equal to status bit n. Status register 0x20 bit n belongs to channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gpio_in | input | NUM_PINS (86) | Asynchronous GPIO pin vector |
| bus_we | input | 1 | Register write strobe, taken at the rising clock edge |
| bus_addr | input | ADDR_W (8) | Register byte address for reads and writes |
| bus_wdata | input | DATA_W (32) | Register write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| irq_req | output | NUM_CH (32) | Active-high level requests, one per channel |

## Verification
An edge reaching a channel's flag and a software clear of that same flag can fall in one clock cycle. The bench provokes this by timing a clear write so that it is sampled on exactly the edge where a synchronised rising transition sets the flag; that is the third clock after the pin change. The flag must read set afterwards, and a second clear must then remove it. A related near-collision is also exercised: the spurious flag raised by enabling a channel, followed by a clear one idle cycle later, must end with the flag clear.

// File: rtl/gis_pkg.sv
`timescale 1ns/1ps
package gis_pkg;

  // Two-bit sense code per channel; the code values are visible to software.
  typedef enum logic [1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  localparam int SENSE_W = 2;

endpackage

// File: rtl/gis_pin_sync.sv
`timescale 1ns/1ps
module gis_pin_sync #(
  parameter int WIDTH = 86
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;

endmodule

// File: rtl/gis_regfile.sv
`timescale 1ns/1ps
module gis_regfile #(
  parameter int NUM_CH      = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int FIELD_W     = 8,
  parameter int STATUS_ADDR = 'h20,
  parameter int CLEAR_ADDR  = 'h24,
  parameter int SENSE_BASE  = 'h28,
  parameter int SELECT_BASE = 'h30
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_CH-1:0]             status_i,
  output logic [NUM_CH*FIELD_W-1:0]     sel_cfg_o,
  output logic [NUM_CH*gis_pkg::SENSE_W-1:0] sense_cfg_o,
  output logic [NUM_CH-1:0]             clr_o
);

  localparam int SEL_PER_REG = DATA_W / FIELD_W;
  localparam int NUM_SEL_REG = NUM_CH / SEL_PER_REG;
  localparam int SNS_PER_REG = DATA_W / gis_pkg::SENSE_W;
  localparam int NUM_SNS_REG = NUM_CH / SNS_PER_REG;

  logic [DATA_W-1:0] sel_q [NUM_SEL_REG];
  logic [DATA_W-1:0] sns_q [NUM_SNS_REG];
  logic              clr_hit;

  // Select registers: one clock enable per word.
  for (genvar k = 0; k < NUM_SEL_REG; k++) begin : g_sel
    logic sel_we;
    assign sel_we = bus_we && (bus_addr == ADDR_W'(SELECT_BASE + 4*k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q[k] <= '0;
      else if (sel_we) sel_q[k] <= bus_wdata;
    end
    assign sel_cfg_o[k*DATA_W +: DATA_W] = sel_q[k];
  end

  // Sense registers.
  for (genvar k = 0; k < NUM_SNS_REG; k++) begin : g_sns
    logic sns_we;
    assign sns_we = bus_we && (bus_addr == ADDR_W'(SENSE_BASE + 4*k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sns_q[k] <= '0;
      else if (sns_we) sns_q[k] <= bus_wdata;
    end
    assign sense_cfg_o[k*DATA_W +: DATA_W] = sns_q[k];
  end

  // Write-one-to-clear pulse, one cycle wide, per channel.
  assign clr_hit = bus_we && (bus_addr == ADDR_W'(CLEAR_ADDR));
  assign clr_o   = clr_hit ? bus_wdata[NUM_CH-1:0] : '0;

  // Read multiplexer.
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(STATUS_ADDR)) bus_rdata = DATA_W'(status_i);
    for (int k = 0; k < NUM_SEL_REG; k++) begin
      if (bus_addr == ADDR_W'(SELECT_BASE + 4*k)) bus_rdata = sel_q[k];
    end
    for (int k = 0; k < NUM_SNS_REG; k++) begin
      if (bus_addr == ADDR_W'(SENSE_BASE + 4*k)) bus_rdata = sns_q[k];
    end
  end

  AST_CLR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_o) |-> (bus_we && bus_addr == ADDR_W'(CLEAR_ADDR)));  // R6

endmodule

// File: rtl/gis_channel.sv
`timescale 1ns/1ps
module gis_channel
  import gis_pkg::*;
#(
  parameter int NUM_PINS = 86,
  parameter int IDX_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                en_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  sense_e              sense_i,
  input  logic                clr_i,
  output logic                flag_o
);

  localparam int PAD_W = 2**IDX_W;

  logic [PAD_W-1:0] pins_pad;
  logic             sel_pin;
  logic             prev_q, prev_d;
  logic             flag_q, flag_d;
  logic             edge_mode;
  logic             edge_hit;

  // Indices past the last pin land on zero padding: constant low source.
  assign pins_pad  = PAD_W'(pins_i);
  assign sel_pin   = pins_pad[idx_i];
  assign edge_mode = (sense_i == SENSE_RISE) || (sense_i == SENSE_FALL);

  always_comb begin
    unique case (sense_i)
      SENSE_RISE: edge_hit = sel_pin & ~prev_q;
      SENSE_FALL: edge_hit = ~sel_pin & prev_q;
      default:    edge_hit = 1'b0;
    endcase
  end

  // Next-state logic. Edge set has priority over clear.
  always_comb begin
    prev_d = en_i ? sel_pin : 1'b0;
    flag_d = flag_q;
    if (!en_i) begin
      flag_d = 1'b0;
    end else if (sense_i == SENSE_HIGH) begin
      flag_d = sel_pin;
    end else if (sense_i == SENSE_LOW) begin
      flag_d = ~sel_pin;
    end else if (edge_hit) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !flag_o);  // R8
  AST_EDGE_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && edge_mode && flag_o && !clr_i) |=> flag_o);  // R3
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && edge_mode && edge_hit && clr_i) |=> flag_o);  // R7
  AST_CLEAR_EDGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && edge_mode && clr_i && !edge_hit) |=> !flag_o);  // R6
  AST_LEVEL_HIGH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && sense_i == SENSE_HIGH) |=> (flag_o == $past(sel_pin)));  // R5

endmodule

// File: rtl/gpio_irq_selector.sv
`timescale 1ns/1ps
module gpio_irq_selector
  import gis_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int NUM_PINS = 86,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int FIELD_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] gpio_in,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_CH-1:0]   irq_req
);

  localparam int IDX_W = FIELD_W - 1;

  logic                          rst_meta_q, rst_sync_q;
  logic [NUM_PINS-1:0]           pins_s;
  logic [NUM_CH*FIELD_W-1:0]     sel_cfg;
  logic [NUM_CH*SENSE_W-1:0]     sense_cfg;
  logic [NUM_CH-1:0]             clr_vec;
  logic [NUM_CH-1:0]             flags;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  gis_pin_sync #(.WIDTH(NUM_PINS)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .din   (gpio_in),
    .dout  (pins_s)
  );

  gis_regfile #(
    .NUM_CH  (NUM_CH),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .FIELD_W (FIELD_W)
  ) u_regfile (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .status_i    (flags),
    .sel_cfg_o   (sel_cfg),
    .sense_cfg_o (sense_cfg),
    .clr_o       (clr_vec)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    gis_channel #(
      .NUM_PINS (NUM_PINS),
      .IDX_W    (IDX_W)
    ) u_channel (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .pins_i  (pins_s),
      .en_i    (sel_cfg[n*FIELD_W + FIELD_W - 1]),
      .idx_i   (sel_cfg[n*FIELD_W +: IDX_W]),
      .sense_i (sense_e'(sense_cfg[n*SENSE_W +: SENSE_W])),
      .clr_i   (clr_vec[n]),
      .flag_o  (flags[n])
    );
  end

  assign irq_req = flags;

endmodule

// File: tb/gpio_irq_selector_bench.sv
`timescale 1ns/1ps
module gpio_irq_selector_bench;

  localparam int NP = 86;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] gpio_in;
  logic          bus_we;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [31:0]   irq_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_selector u_gpio_irq_selector (
    .clk       (clk),
    .rst_n     (rst_n),
    .gpio_in   (gpio_in),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_status(string tag, logic [31:0] exp);
    logic [31:0] d;
    bus_read(8'h20, d);
    check({tag, " status"}, d, exp);
    check({tag, " irq_req R11"}, irq_req, exp);
  endtask

  task automatic cfg(int ch, int idx, bit en, int sense);
    bus_write(8'(8'h28 + 4*(ch/16)), 32'(sense) << (2*(ch%16)));
    bus_write(8'(8'h30 + 4*(ch/4)), 32'({en, 7'(idx)}) << (8*(ch%4)));
  endtask

  task automatic cleanup();
    gpio_in = '0;
    bus_write(8'h34, 32'h0);
    bus_write(8'h44, 32'h0);
    bus_write(8'h28, 32'h0);
    bus_write(8'h2C, 32'h0);
    cycles(4);
    bus_write(8'h24, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    expect_status("R1 reset", 32'h0);
    bus_read(8'h30, d); check("R1 select reset", d, 32'h0);
    bus_read(8'h28, d); check("R1 sense reset", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(8'h38, 32'h7F80D512);
    bus_read(8'h38, d); check("R2 select readback", d, 32'h7F80D512);
    bus_write(8'h2C, 32'hDEADBEEF);
    bus_read(8'h2C, d); check("R2 sense readback", d, 32'hDEADBEEF);
    bus_read(8'h28, d); check("R2 other sense untouched", d, 32'h0);
    bus_write(8'h20, 32'hFFFF_FFFF);
    expect_status("R2 status write ignored", 32'h0);
    bus_read(8'h24, d); check("R2 clear reads zero", d, 32'h0);
    bus_write(8'h2C, 32'h0);
    bus_write(8'h38, 32'h0);
  endtask

  task automatic t_rise();
    cfg(5, 17, 1'b1, 0);
    gpio_in[17] = 1'b1;
    cycles(2); expect_status("R3 before latency", 32'h0);
    cycles(1); expect_status("R3 rise sets", 32'h20);
    gpio_in[17] = 1'b0;
    cycles(4); expect_status("R3 held after fall", 32'h20);
    bus_write(8'h24, 32'h20);
    expect_status("R6 edge clear", 32'h0);
    cleanup();
  endtask

  task automatic t_fall();
    gpio_in[85] = 1'b1;
    cycles(3);
    cfg(21, 8'h55, 1'b1, 1);
    cycles(2); expect_status("R4 no flag while high", 32'h0);
    gpio_in[85] = 1'b0;
    cycles(2); expect_status("R4 before latency", 32'h0);
    cycles(1); expect_status("R4 fall sets pin 0x55", 32'h0020_0000);
    bus_write(8'h24, 32'h0020_0000);
    expect_status("R6 clear falling", 32'h0);
    cleanup();
  endtask

  task automatic t_level();
    cfg(5, 17, 1'b1, 2);
    cycles(1); expect_status("R5 high idle", 32'h0);
    gpio_in[17] = 1'b1;
    cycles(3); expect_status("R5 high follows", 32'h20);
    bus_write(8'h24, 32'h20);
    expect_status("R6 clear ignored in level", 32'h20);
    gpio_in[17] = 1'b0;
    cycles(3); expect_status("R5 high drops", 32'h0);
    bus_write(8'h28, 32'h3 << 10);
    cycles(1); expect_status("R5 low level active", 32'h20);
    gpio_in[17] = 1'b1;
    cycles(3); expect_status("R5 low level drops", 32'h0);
    cleanup();
  endtask

  task automatic t_collision();
    cfg(5, 17, 1'b1, 0);
    cycles(1);
    gpio_in[17] = 1'b1;
    cycles(2);
    bus_write(8'h24, 32'h20);  // taken on the edge that records the rise
    expect_status("R7 edge wins over clear", 32'h20);
    bus_write(8'h24, 32'h20);
    expect_status("R7 later clear works", 32'h0);
    cleanup();
  endtask

  task automatic t_disabled();
    cfg(5, 17, 1'b0, 0);
    gpio_in[17] = 1'b1;
    cycles(4); expect_status("R8 disabled edge ignored", 32'h0);
    gpio_in[17] = 1'b0;
    cfg(5, 17, 1'b0, 3);
    cycles(4); expect_status("R8 disabled level ignored", 32'h0);
    cleanup();
  endtask

  task automatic t_invalid();
    gpio_in = '1;
    cycles(3);
    cfg(5, 8'h56, 1'b1, 3);
    cycles(2); expect_status("R9 index 0x56 low", 32'h20);
    cfg(5, 17, 1'b1, 3);
    cycles(2); expect_status("R9 valid index high", 32'h0);
    cfg(5, 8'h7F, 1'b1, 3);
    cycles(2); expect_status("R9 index 0x7F low", 32'h20);
    cleanup();
  endtask

  task automatic t_glitch();
    cfg(5, 17, 1'b0, 0);
    gpio_in[17] = 1'b1;
    cycles(3);
    bus_write(8'h34, 32'h0000_9100);  // enable, index 17
    cycles(1); expect_status("R10 spurious flag", 32'h20);
    bus_write(8'h24, 32'h20);
    expect_status("R10 clear removes spurious", 32'h0);
    cycles(3); expect_status("R10 stays clear", 32'h0);
    cleanup();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; gpio_in = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(3);
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_level();
    t_collision();
    t_disabled();
    t_invalid();
    t_glitch();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule